// File: doc/BRIEF.md
# Station Address Loader

After reset, this block fetches four consecutive 16-bit words from a serial configuration memory through a word-read port. It rebuilds the 48-bit station address from those words. The address is not word aligned in the memory: it starts at the top bit of the first word fetched, so every byte spans a word boundary.

Once the address is rebuilt, the block programs a receive address filter through an indexed register pair. For each 16-bit slice of the address it writes an index to the index register and then the slice to the data register. It then writes a control word that accepts broadcast frames and frames addressed to the station, and rejects multicast.

The rebuilt address is presented on a 48-bit output with a valid flag. A new load runs on reset release or on a start pulse that arrives while the block is idle.

Top module: `station_addr_loader`

## Requirements
- R1: While reset is asserted, `addr_valid`, `flt_wr` and `rd_req` are low. A load starts by itself on the first clock after reset is released.
- R2: A load reads the words at `FIRST_WORD` to `FIRST_WORD+3` (default 6 to 9) in ascending order, one read at a time. `rd_req` and `rd_addr` are held steady until `rd_ack` is seen.
- R3: Let the words be w0 (`FIRST_WORD`) through w3. Address byte n sits at `station_addr[8n+7:8n]`. For k = 0..2, byte 2k is bits 6:0 of w(k+1) above bit 15 of w(k) as its LSB, and byte 2k+1 is bits 14:7 of w(k+1). The other bits of w0 are unused.
- R4: The filter is programmed with exactly seven single-cycle writes, in this order: index 0, entry 0, index 2, entry 1, index 4, entry 2, control. `flt_reg` = 0 selects the index register and 1 selects the data register. Entry k is `station_addr[16k+15:16k]` zero-extended to 32 bits, so byte 2k is in the low half and byte 2k+1 is in the high half.
- R5: The seventh write goes to the index register (`flt_reg` = 0) and carries `FILT_CTRL`. The default is 32'hC800_0000: bits 31:30 accept broadcast, bit 27 accepts the station address, and multicast bit 21 is clear.
- R6: `addr_valid` is low during the write of the third address entry and rises on the following clock.
- R7: While `addr_valid` is high, `station_addr` does not change, even when the memory contents change.
- R8: A start pulse while idle begins a new load and clears `addr_valid` on that same clock.
- R9: A start pulse during a load, whether in the read or the write phase, is ignored. The load still performs exactly four reads and seven writes.
- R10: No read request is outstanding while a filter write is being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new load (single-cycle pulse) |
| rd_req | output | 1 | Word read request, held until acknowledged |
| rd_addr | output | EE_AW | Word address of the pending read |
| rd_ack | input | 1 | One-cycle acknowledge; `rd_data` is valid in that cycle |
| rd_data | input | 16 | Word returned by the read port |
| station_addr | output | 48 | Rebuilt station address |
| addr_valid | output | 1 | Station address is complete and stable |
| flt_wr | output | 1 | Filter register write strobe |
| flt_reg | output | 1 | Filter register select: 0 index/control, 1 data |
| flt_wdata | output | FLT_W | Filter write data |

## Verification
The checks assume that the word-read port raises `rd_ack` for exactly one cycle and only while `rd_req` is high, with `rd_data` valid in that cycle, and that `start` is a single-cycle pulse. The bench memory model follows this handshake: it waits one clock after seeing a request, drives a single acknowledge, and never acknowledges twice for the same request. Start pulses are one clock wide. They are deliberately placed during both the read phase and the write phase to cover the ignore rule.

// File: rtl/sal_pkg.sv
package sal_pkg;
   localparam int WORD_W  = 16;
   localparam int ENTRY_N = 3;
   typedef enum logic {REG_INDEX = 1'b0, REG_DATA = 1'b1} flt_reg_e;
endpackage

// File: rtl/sal_fetch.sv
module sal_fetch
   import sal_pkg::*;
#(
   parameter int EE_AW      = 6,
   parameter int FIRST_WORD = 6,
   parameter int NWORDS     = 4,
   localparam int CW        = $clog2(NWORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   output logic              rd_req,
   output logic [EE_AW-1:0]  rd_addr,
   input  logic              rd_ack,
   input  logic [WORD_W-1:0] rd_data,
   output logic              wvld,
   output logic [CW-1:0]     widx,
   output logic [WORD_W-1:0] wdata,
   output logic              done,
   output logic              busy
);
   localparam logic [CW-1:0]    LAST  = CW'(NWORDS - 1);
   localparam logic [EE_AW-1:0] START = EE_AW'(FIRST_WORD);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_req  <= 1'b0;
         rd_addr <= START;
         cnt     <= '0;
         wvld    <= 1'b0;
         widx    <= '0;
         wdata   <= '0;
         done    <= 1'b0;
      end else begin
         wvld <= 1'b0;
         done <= 1'b0;
         if (!rd_req) begin
            if (go) begin
               rd_req  <= 1'b1;
               rd_addr <= START;
               cnt     <= '0;
            end
         end else if (rd_ack) begin
            wvld  <= 1'b1;
            widx  <= cnt;
            wdata <= rd_data;
            if (cnt == LAST) begin
               rd_req <= 1'b0;
               done   <= 1'b1;
            end else begin
               cnt     <= cnt + 1'b1;
               rd_addr <= rd_addr + 1'b1;
            end
         end
      end
   end

   assign busy = rd_req | wvld | done;
endmodule

// File: rtl/sal_assemble.sv
module sal_assemble
   import sal_pkg::*;
#(
   parameter int NWORDS = 4,
   localparam int CW    = $clog2(NWORDS + 1),
   localparam int NENT  = NWORDS - 1,
   localparam int MAC_W = WORD_W * NENT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wvld,
   input  logic [CW-1:0]     widx,
   input  logic [WORD_W-1:0] wdata,
   output logic [MAC_W-1:0]  mac
);
   logic carry;

   always_ff @(posedge clk) begin
      if (!rst_n)    carry <= 1'b0;
      else if (wvld) carry <= wdata[WORD_W-1];
   end

   for (genvar k = 0; k < NENT; k++) begin : g_ent
      logic [WORD_W-1:0] ent;
      always_ff @(posedge clk) begin
         if (!rst_n)
            ent <= '0;
         else if (wvld && widx == CW'(k + 1))
            ent <= {wdata[WORD_W-2:0], carry};
      end
      assign mac[k*WORD_W +: WORD_W] = ent;
   end
endmodule

// File: rtl/sal_fwrite.sv
module sal_fwrite
   import sal_pkg::*;
#(
   parameter int          NENT      = 3,
   parameter int          FLT_W     = 32,
   parameter int          IDX_STEP  = 2,
   parameter logic [31:0] FILT_CTRL = 32'hC800_0000,
   localparam int         MAC_W     = WORD_W * NENT,
   localparam int         NSTEP     = 2 * NENT + 1,
   localparam int         SW        = $clog2(NSTEP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [MAC_W-1:0] mac,
   output logic             flt_wr,
   output flt_reg_e         flt_reg,
   output logic [FLT_W-1:0] flt_wdata,
   output logic             last_entry,
   output logic             busy
);
   logic [SW-1:0]     step;
   logic [SW-1:0]     half;
   logic              active;
   logic [WORD_W-1:0] entry_sel;
   logic [FLT_W-1:0]  idx_val;

   assign half = step >> 1;

   always_comb begin
      entry_sel = '0;
      for (int k = 0; k < NENT; k++)
         if (half == SW'(k)) entry_sel = mac[k*WORD_W +: WORD_W];
      idx_val = FLT_W'(half) * FLT_W'(IDX_STEP);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active     <= 1'b0;
         step       <= '0;
         flt_wr     <= 1'b0;
         flt_reg    <= REG_INDEX;
         flt_wdata  <= '0;
         last_entry <= 1'b0;
      end else begin
         flt_wr     <= 1'b0;
         last_entry <= 1'b0;
         if (!active) begin
            if (go) begin
               active <= 1'b1;
               step   <= '0;
            end
         end else begin
            flt_wr <= 1'b1;
            step   <= step + 1'b1;
            if (step == SW'(NSTEP - 1)) begin
               active    <= 1'b0;
               flt_reg   <= REG_INDEX;
               flt_wdata <= FLT_W'(FILT_CTRL);
            end else if (!step[0]) begin
               flt_reg   <= REG_INDEX;
               flt_wdata <= idx_val;
            end else begin
               flt_reg    <= REG_DATA;
               flt_wdata  <= FLT_W'(entry_sel);
               last_entry <= (step == SW'(2 * NENT - 1));
            end
         end
      end
   end

   assign busy = active;
endmodule

// File: rtl/station_addr_loader.sv
module station_addr_loader
   import sal_pkg::*;
#(
   parameter int          EE_AW      = 6,
   parameter int          FIRST_WORD = 6,
   parameter int          FLT_W      = 32,
   parameter int          IDX_STEP   = 2,
   parameter logic [31:0] FILT_CTRL  = 32'hC800_0000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   output logic                  rd_req,
   output logic [EE_AW-1:0]      rd_addr,
   input  logic                  rd_ack,
   input  logic [15:0]           rd_data,
   output logic [47:0]           station_addr,
   output logic                  addr_valid,
   output logic                  flt_wr,
   output logic                  flt_reg,
   output logic [FLT_W-1:0]      flt_wdata
);
   localparam int NWORDS = ENTRY_N + 1;
   localparam int CW     = $clog2(NWORDS + 1);
   localparam int MAC_W  = WORD_W * ENTRY_N;

   if (FIRST_WORD + NWORDS > (1 << EE_AW)) begin : g_bad_range
      $error("word window exceeds read address space");
   end
   if (FLT_W < WORD_W) begin : g_bad_width
      $error("filter data narrower than an address entry");
   end
   if (MAC_W != 48) begin : g_bad_mac
      $error("station address must be 48 bits");
   end

   logic              boot, go, busy;
   logic              f_busy, w_busy, f_done, last_entry;
   logic              wvld;
   logic [CW-1:0]     widx;
   logic [WORD_W-1:0] wdata;
   flt_reg_e          w_reg;

   always_ff @(posedge clk) begin
      if (!rst_n) boot <= 1'b1;
      else        boot <= 1'b0;
   end

   assign busy = f_busy | w_busy;
   assign go   = (start | boot) & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n)          addr_valid <= 1'b0;
      else if (go)         addr_valid <= 1'b0;
      else if (last_entry) addr_valid <= 1'b1;
   end

   sal_fetch #(.EE_AW(EE_AW), .FIRST_WORD(FIRST_WORD), .NWORDS(NWORDS)) i_fetch (
      .clk(clk), .rst_n(rst_n), .go(go),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .wvld(wvld), .widx(widx), .wdata(wdata), .done(f_done), .busy(f_busy)
   );

   sal_assemble #(.NWORDS(NWORDS)) i_asm (
      .clk(clk), .rst_n(rst_n), .wvld(wvld), .widx(widx), .wdata(wdata),
      .mac(station_addr)
   );

   sal_fwrite #(.NENT(ENTRY_N), .FLT_W(FLT_W), .IDX_STEP(IDX_STEP),
                .FILT_CTRL(FILT_CTRL)) i_fwr (
      .clk(clk), .rst_n(rst_n), .go(f_done), .mac(station_addr),
      .flt_wr(flt_wr), .flt_reg(w_reg), .flt_wdata(flt_wdata),
      .last_entry(last_entry), .busy(w_busy)
   );

   assign flt_reg = w_reg;
endmodule

// File: rtl/sal_chk.sv
module sal_chk #(
   parameter int EE_AW      = 6,
   parameter int FIRST_WORD = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_req,
   input logic [EE_AW-1:0] rd_addr,
   input logic             rd_ack,
   input logic [47:0]      station_addr,
   input logic             addr_valid,
   input logic             flt_wr,
   input logic             flt_reg
);
   // R2: request and address stay put until acknowledged
   a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

   // R2: reads stay inside the four-word window
   a_r2_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (int'(rd_addr) >= FIRST_WORD && int'(rd_addr) <= FIRST_WORD + 3));

   // R4: every data-register write directly follows an index write
   a_r4_data_after_index: assert property (@(posedge clk) disable iff (!rst_n)
      flt_wr && flt_reg |-> $past(flt_wr && !flt_reg));

   // R6: valid rises only right after a data-register write
   a_r6_valid_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_valid) |-> $past(flt_wr && flt_reg));

   // R8: valid is low whenever a read is outstanding
   a_r8_valid_low_loading: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !addr_valid);

   // R7: address frozen while valid
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |=> !addr_valid || $stable(station_addr));

   // R10: reads and filter writes never overlap
   a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      flt_wr |-> !rd_req);
endmodule

bind station_addr_loader sal_chk #(.EE_AW(EE_AW), .FIRST_WORD(FIRST_WORD)) i_chk (
   .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
   .station_addr(station_addr), .addr_valid(addr_valid),
   .flt_wr(flt_wr), .flt_reg(flt_reg)
);

// File: tb/test_station_addr_loader.sv
`timescale 1ns/1ps
module test_station_addr_loader;
   logic        clk = 1'b0;
   logic        rst_n, start;
   logic        rd_req, rd_ack;
   logic [5:0]  rd_addr;
   logic [15:0] rd_data;
   logic [47:0] station_addr;
   logic        addr_valid, flt_wr, flt_reg;
   logic [31:0] flt_wdata;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [15:0] mem [64];
   int          wait_cnt;
   int          rd_n, wr_n;
   logic [5:0]  rd_log [16];
   logic        wr_reg_log [16];
   logic [31:0] wr_dat_log [16];
   logic        wr_vld_log [16];
   logic        wr_req_log [16];

   // words at 6..9, then expected address
   localparam logic [111:0] VEC [4] = '{
      {16'h8000, 16'h0000, 16'h0000, 16'h0000, 48'h0000_0000_0001},
      {16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 48'h0000_0001_FFFE},
      {16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 48'hFFFE_0000_0000},
      {16'hFFFF, 16'h1234, 16'h8000, 16'h0001, 48'h0003_0000_2469}
   };

   station_addr_loader i_station_addr_loader (
      .clk(clk), .rst_n(rst_n), .start(start),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .station_addr(station_addr), .addr_valid(addr_valid),
      .flt_wr(flt_wr), .flt_reg(flt_reg), .flt_wdata(flt_wdata)
   );

   always #10 clk = ~clk;

   // word-read model and filter write logger
   always @(negedge clk) begin
      if (rd_ack) rd_ack = 1'b0;
      else if (rd_req) begin
         if (wait_cnt >= 1) begin
            rd_ack  = 1'b1;
            rd_data = mem[rd_addr];
            if (rd_n < 16) rd_log[rd_n] = rd_addr;
            rd_n++;
            wait_cnt = 0;
         end else wait_cnt++;
      end
      if (flt_wr) begin
         if (wr_n < 16) begin
            wr_reg_log[wr_n] = flt_reg;
            wr_dat_log[wr_n] = flt_wdata;
            wr_vld_log[wr_n] = addr_valid;
            wr_req_log[wr_n] = rd_req;
         end
         wr_n++;
      end
   end

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic report;
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic clear_logs;
      @(posedge clk); #5;
      rd_n = 0;
      wr_n = 0;
   endtask

   task automatic load_vec(int v);
      mem[6] = VEC[v][111:96];
      mem[7] = VEC[v][95:80];
      mem[8] = VEC[v][79:64];
      mem[9] = VEC[v][63:48];
   endtask

   task automatic pulse_start;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_valid(string req);
      bit ok = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (addr_valid) begin ok = 1; break; end
      end
      chk(req, "load completes", 64'(ok), 64'd1);
   endtask

   task automatic check_load(int v);
      logic [47:0] exp = VEC[v][47:0];
      logic [15:0] w [4];
      w[0] = VEC[v][111:96]; w[1] = VEC[v][95:80];
      w[2] = VEC[v][79:64];  w[3] = VEC[v][63:48];
      chk("R3", "address vs table", 64'(station_addr), 64'(exp));
      for (int n = 0; n < 6; n++) begin
         logic [7:0] b;
         if (n % 2 == 0) b = {w[n/2+1][6:0], w[n/2][15]};
         else            b = w[n/2+1][14:7];
         chk("R3", $sformatf("byte %0d", n), 64'(station_addr[8*n +: 8]), 64'(b));
      end
      chk("R2", "read count", 64'(rd_n), 64'd4);
      for (int i = 0; i < 4; i++)
         chk("R2", $sformatf("read %0d address", i), 64'(rd_log[i]), 64'(6 + i));
      chk("R4", "write count", 64'(wr_n), 64'd7);
      for (int k = 0; k < 3; k++) begin
         chk("R4", $sformatf("index %0d select", k), 64'(wr_reg_log[2*k]), 64'd0);
         chk("R4", $sformatf("index %0d value", k), 64'(wr_dat_log[2*k]), 64'(2*k));
         chk("R4", $sformatf("entry %0d select", k), 64'(wr_reg_log[2*k+1]), 64'd1);
         chk("R4", $sformatf("entry %0d value", k), 64'(wr_dat_log[2*k+1]),
             64'({16'h0, exp[16*k +: 16]}));
      end
      chk("R5", "control select", 64'(wr_reg_log[6]), 64'd0);
      chk("R5", "control word", 64'(wr_dat_log[6]), 64'h0000_0000_C800_0000);
      chk("R6", "valid low at third entry", 64'(wr_vld_log[5]), 64'd0);
      chk("R6", "valid high next cycle", 64'(wr_vld_log[6]), 64'd1);
      for (int i = 0; i < 7; i++)
         chk("R10", $sformatf("no read during write %0d", i), 64'(wr_req_log[i]), 64'd0);
   endtask

   initial begin
      #(20ns * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; rd_ack = 1'b0; rd_data = '0;
      wait_cnt = 0; rd_n = 0; wr_n = 0;
      for (int i = 0; i < 64; i++) mem[i] = 16'hA5A5;
      load_vec(0);
      repeat (3) @(negedge clk);
      chk("R1", "valid in reset", 64'(addr_valid), 64'd0);
      chk("R1", "write in reset", 64'(flt_wr), 64'd0);
      chk("R1", "read in reset", 64'(rd_req), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R1", "auto load after reset", 64'(rd_req), 64'd1);
      wait_valid("R1");
      repeat (3) @(negedge clk);
      check_load(0);

      // table walk with start pulses
      for (int v = 1; v < 4; v++) begin
         clear_logs();
         load_vec(v);
         pulse_start();
         chk("R8", "valid cleared by start", 64'(addr_valid), 64'd0);
         wait_valid("R8");
         repeat (3) @(negedge clk);
         check_load(v);
      end

      // hold while valid, memory changed behind it
      clear_logs();
      load_vec(0);
      repeat (20) @(negedge clk);
      chk("R7", "address held", 64'(station_addr), 64'(VEC[3][47:0]));
      chk("R7", "valid held", 64'(addr_valid), 64'd1);
      chk("R7", "no reads without start", 64'(rd_n), 64'd0);

      // start during the read phase
      clear_logs();
      load_vec(1);
      pulse_start();
      repeat (2) @(negedge clk);
      pulse_start();
      wait_valid("R9");
      repeat (30) @(negedge clk);
      chk("R9", "reads with start in read phase", 64'(rd_n), 64'd4);
      chk("R9", "writes with start in read phase", 64'(wr_n), 64'd7);
      chk("R9", "address after read-phase start", 64'(station_addr), 64'(VEC[1][47:0]));

      // start during the write phase
      clear_logs();
      load_vec(2);
      pulse_start();
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (flt_wr) break;
      end
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_valid("R9");
      repeat (30) @(negedge clk);
      chk("R9", "reads with start in write phase", 64'(rd_n), 64'd4);
      chk("R9", "writes with start in write phase", 64'(wr_n), 64'd7);
      chk("R9", "address after write-phase start", 64'(station_addr), 64'(VEC[2][47:0]));

      report();
   end
endmodule